// File: doc/BRIEF.md
# Associative Rename Buffer File

This block is a separate register-rename store for an out-of-order core. It holds eight in-flight results in a circular buffer, next to a model of the architectural register file. Each cycle a single rename request can arrive, naming one destination and two source registers. The destination always gets a fresh entry at the head pointer. Each source is answered from the current contents, without waiting for a clock edge. The answer is either a ready value or, when the newest producer has not finished, the index of the entry that will hold that value.

A result port writes a computed value into the entry named by its index and marks that entry finished. A retire port frees entries strictly in allocation order from the tail pointer. Retiring copies the entry's value into the architectural file. Lookups are associative: each valid entry stores its architectural register number and a newest-instance flag, and only an entry with that flag set can answer. When no entry answers, the architectural file supplies the value.

Occupancy is tracked by a three-state machine:
- EMPTY: no entry is live.
- PARTIAL: some entries are live but not all.
- FULL: every entry is live.

The transitions are:
- fill: an allocation without a retirement in the same cycle. It goes EMPTY to PARTIAL, stays in PARTIAL, or reaches FULL when the last free entry is taken.
- drain: a retirement without an allocation. It goes FULL to PARTIAL, stays in PARTIAL, or reaches EMPTY when the last live entry leaves.
- hold: both an allocation and a retirement, or neither. The state does not change.

Top module: `rnb_top`

## Requirements
- R1: An accepted rename request (`ren_valid` high while `ren_ready` is high) takes the entry at the head. `ren_tag` reports that entry's index. Indices are handed out in order 0,1,...,7 and then wrap back to 0.
- R2: When all 8 entries are live, `ren_ready` is low. A request made in that state allocates nothing, and the head does not move. The next accepted request, after a retirement, receives the index the refused request would have received.
- R3: Renaming a register that already has a live entry still allocates a new entry. From the following cycle on, lookups of that register return the new entry and never the older instance.
- R4: When the newest live entry for a source register has no result yet, the lookup reports `src_x_rdy` = 0, and `src_x_tag` carries that entry's index.
- R5: A result written at index T makes, from the next cycle, lookups that resolve to entry T return `src_x_rdy` = 1 and the written value. The value comes from the entry even when the architectural file holds a different value for that register.
- R6: `ret_ok` is high exactly when `ret_valid` is high, the buffer is not empty, and the tail entry holds a result. When `ret_ok` is high, the tail entry's value is written into the architectural file at the next edge, and the entry is freed. A retire request without `ret_ok` changes nothing.
- R7: A source that names the same register as the destination of the same request sees the mapping that existed before that request. That is either an older entry or the architectural file.
- R8: A register with no live newest entry is answered from the architectural file, with `src_x_rdy` = 1. This includes a register whose newest entry has just retired. After reset, all architectural registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ren_valid | input | 1 | Rename request present |
| ren_dst | input | 3 | Destination architectural register |
| ren_src_a | input | 3 | First source architectural register |
| ren_src_b | input | 3 | Second source architectural register |
| ren_ready | output | 1 | A free entry exists; a request is accepted |
| ren_tag | output | 3 | Entry index given to the destination |
| src_a_rdy | output | 1 | First source value is available |
| src_a_val | output | 16 | First source value, valid when ready |
| src_a_tag | output | 3 | Pending producer entry for first source |
| src_b_rdy | output | 1 | Second source value is available |
| src_b_val | output | 16 | Second source value, valid when ready |
| src_b_tag | output | 3 | Pending producer entry for second source |
| wb_valid | input | 1 | Result write present |
| wb_tag | input | 3 | Entry index receiving the result |
| wb_data | input | 16 | Result value |
| ret_valid | input | 1 | Request to retire the tail entry |
| ret_ok | output | 1 | Tail entry retires at this edge |

## Verification
The main lookup function is tried with five kinds of source pattern:
- registers never renamed, which must come from the architectural file;
- registers whose newest entry is pending, which must return that entry's index and not a value;
- registers renamed twice, which must return the newest index and not the older one;
- sources equal to the destination of the same request, which must return the prior mapping;
- registers whose only entry has retired, which must fall back to the architectural file holding the copied value.

Retire requests are issued against a tail entry that has no result, one that gets its result in the same cycle, and one that is finished. This separates a retirement gated on a registered finished flag from one that is not gated at all. A fill to eight entries, a refused ninth request and a single drain show that the full state stalls allocation without moving the head.

// File: rtl/rnb_pkg.sv
package rnb_pkg;
    localparam int RNB_DEPTH  = 8;
    localparam int RNB_NAREG  = 8;
    localparam int RNB_DWIDTH = 16;

    typedef enum logic [1:0] {
        OCC_EMPTY,
        OCC_PARTIAL,
        OCC_FULL
    } occ_e;
endpackage

// File: rtl/rnb_lookup.sv
module rnb_lookup #(
    parameter int DEPTH = 8,
    parameter int AW    = 3,
    parameter int DW    = 16,
    localparam int TW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ent_valid  [DEPTH],
    input  logic          ent_latest [DEPTH],
    input  logic          ent_done   [DEPTH],
    input  logic [AW-1:0] ent_areg   [DEPTH],
    input  logic [DW-1:0] ent_data   [DEPTH],
    input  logic [AW-1:0] src,
    input  logic [DW-1:0] arch_val,
    output logic          rdy,
    output logic [DW-1:0] val,
    output logic [TW-1:0] tag
);
    logic [DEPTH-1:0] match;

    for (genvar g = 0; g < DEPTH; g++) begin : g_cam
        assign match[g] = ent_valid[g] && ent_latest[g] && (ent_areg[g] == src);
    end

    always_comb begin
        rdy = 1'b1;
        val = arch_val;
        tag = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (match[i]) begin
                tag = TW'(i);
                rdy = ent_done[i];
                val = ent_done[i] ? ent_data[i] : '0;
            end
        end
    end

    // R3: at most one newest instance per register
    p_single_latest_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match));
endmodule

// File: rtl/rnb_ctrl.sv
module rnb_ctrl
    import rnb_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int TW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ren_valid,
    input  logic          ret_valid,
    input  logic          tail_done,
    output logic          can_alloc,
    output logic          alloc_fire,
    output logic          retire_fire,
    output logic [TW-1:0] head,
    output logic [TW-1:0] tail
);
    occ_e          state, state_nxt;
    logic [CW-1:0] count, count_nxt;

    always_comb begin
        can_alloc   = 1'b0;
        alloc_fire  = 1'b0;
        retire_fire = 1'b0;
        unique case (state)
            OCC_EMPTY: begin
                can_alloc  = 1'b1;
                alloc_fire = ren_valid;
            end
            OCC_PARTIAL: begin
                can_alloc   = 1'b1;
                alloc_fire  = ren_valid;
                retire_fire = ret_valid && tail_done;
            end
            OCC_FULL: begin
                retire_fire = ret_valid && tail_done;
            end
            default: ;
        endcase
        count_nxt = count + CW'(alloc_fire) - CW'(retire_fire);
        if (count_nxt == '0)
            state_nxt = OCC_EMPTY;
        else if (count_nxt == CW'(DEPTH))
            state_nxt = OCC_FULL;
        else
            state_nxt = OCC_PARTIAL;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= OCC_EMPTY;
            count <= '0;
            head  <= '0;
            tail  <= '0;
        end else begin
            state <= state_nxt;
            count <= count_nxt;
            if (alloc_fire)  head <= (head == TW'(DEPTH - 1)) ? '0 : head + 1'b1;
            if (retire_fire) tail <= (tail == TW'(DEPTH - 1)) ? '0 : tail + 1'b1;
        end
    end

    // R2: nothing is allocated while every entry is live
    p_no_alloc_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == OCC_FULL) |-> !alloc_fire);
    // R1: head advances by one per accepted request
    p_head_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_fire |=> head == (($past(head) == TW'(DEPTH - 1)) ? '0 : $past(head) + 1'b1));
    // R6: nothing retires from an empty buffer
    p_no_retire_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == OCC_EMPTY) |-> !retire_fire);
endmodule

// File: rtl/rnb_top.sv
module rnb_top
    import rnb_pkg::*;
#(
    parameter int DEPTH = RNB_DEPTH,
    parameter int NAREG = RNB_NAREG,
    parameter int DW    = RNB_DWIDTH,
    localparam int TW   = $clog2(DEPTH),
    localparam int AW   = $clog2(NAREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ren_valid,
    input  logic [AW-1:0] ren_dst,
    input  logic [AW-1:0] ren_src_a,
    input  logic [AW-1:0] ren_src_b,
    output logic          ren_ready,
    output logic [TW-1:0] ren_tag,
    output logic          src_a_rdy,
    output logic [DW-1:0] src_a_val,
    output logic [TW-1:0] src_a_tag,
    output logic          src_b_rdy,
    output logic [DW-1:0] src_b_val,
    output logic [TW-1:0] src_b_tag,
    input  logic          wb_valid,
    input  logic [TW-1:0] wb_tag,
    input  logic [DW-1:0] wb_data,
    input  logic          ret_valid,
    output logic          ret_ok
);
    logic          ent_valid  [DEPTH];
    logic          ent_latest [DEPTH];
    logic          ent_done   [DEPTH];
    logic [AW-1:0] ent_areg   [DEPTH];
    logic [DW-1:0] ent_data   [DEPTH];
    logic [DW-1:0] arch       [NAREG];

    logic          alloc_fire, retire_fire, can_alloc;
    logic [TW-1:0] head, tail;

    rnb_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .ren_valid(ren_valid), .ret_valid(ret_valid),
        .tail_done(ent_done[tail]),
        .can_alloc(can_alloc), .alloc_fire(alloc_fire), .retire_fire(retire_fire),
        .head(head), .tail(tail)
    );

    assign ren_ready = can_alloc;
    assign ren_tag   = head;
    assign ret_ok    = retire_fire;

    rnb_lookup #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_look_a (
        .clk(clk), .rst_n(rst_n),
        .ent_valid(ent_valid), .ent_latest(ent_latest), .ent_done(ent_done),
        .ent_areg(ent_areg), .ent_data(ent_data),
        .src(ren_src_a), .arch_val(arch[ren_src_a]),
        .rdy(src_a_rdy), .val(src_a_val), .tag(src_a_tag)
    );

    rnb_lookup #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_look_b (
        .clk(clk), .rst_n(rst_n),
        .ent_valid(ent_valid), .ent_latest(ent_latest), .ent_done(ent_done),
        .ent_areg(ent_areg), .ent_data(ent_data),
        .src(ren_src_b), .arch_val(arch[ren_src_b]),
        .rdy(src_b_rdy), .val(src_b_val), .tag(src_b_tag)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                ent_valid[i]  <= 1'b0;
                ent_latest[i] <= 1'b0;
                ent_done[i]   <= 1'b0;
                ent_areg[i]   <= '0;
                ent_data[i]   <= '0;
            end
            for (int r = 0; r < NAREG; r++) arch[r] <= '0;
        end else begin
            if (wb_valid && ent_valid[wb_tag]) begin
                ent_data[wb_tag] <= wb_data;
                ent_done[wb_tag] <= 1'b1;
            end
            if (retire_fire) begin
                arch[ent_areg[tail]] <= ent_data[tail];
                ent_valid[tail]      <= 1'b0;
                ent_latest[tail]     <= 1'b0;
            end
            if (alloc_fire) begin
                for (int i = 0; i < DEPTH; i++)
                    if (ent_valid[i] && ent_areg[i] == ren_dst) ent_latest[i] <= 1'b0;
                ent_valid[head]  <= 1'b1;
                ent_latest[head] <= 1'b1;
                ent_done[head]   <= 1'b0;
                ent_areg[head]   <= ren_dst;
            end
        end
    end

    // R1: a newly allocated entry is live, newest and still pending
    p_fresh_entry_r1: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_fire |=> ent_valid[$past(head)] && ent_latest[$past(head)] && !ent_done[$past(head)]);
    // R6: retirement only of a finished tail entry
    p_retire_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        retire_fire |-> ent_valid[tail] && ent_done[tail]);
    // R6: the retired value reaches the architectural file
    p_retire_copy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        retire_fire |=> arch[$past(ent_areg[tail])] == $past(ent_data[tail]));
    // R4: a pending answer always names a live entry
    p_pending_live_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !src_a_rdy |-> ent_valid[src_a_tag] && !ent_done[src_a_tag]);
endmodule

// File: tb/rnb_top_test.sv
`timescale 1ns/1ps
module rnb_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ren_valid = 1'b0;
    logic [2:0]  ren_dst = '0, ren_src_a = '0, ren_src_b = '0;
    logic        ren_ready;
    logic [2:0]  ren_tag;
    logic        src_a_rdy, src_b_rdy;
    logic [15:0] src_a_val, src_b_val;
    logic [2:0]  src_a_tag, src_b_tag;
    logic        wb_valid = 1'b0;
    logic [2:0]  wb_tag = '0;
    logic [15:0] wb_data = '0;
    logic        ret_valid = 1'b0;
    logic        ret_ok;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    rnb_top uut (
        .clk(clk), .rst_n(rst_n),
        .ren_valid(ren_valid), .ren_dst(ren_dst), .ren_src_a(ren_src_a), .ren_src_b(ren_src_b),
        .ren_ready(ren_ready), .ren_tag(ren_tag),
        .src_a_rdy(src_a_rdy), .src_a_val(src_a_val), .src_a_tag(src_a_tag),
        .src_b_rdy(src_b_rdy), .src_b_val(src_b_val), .src_b_tag(src_b_tag),
        .wb_valid(wb_valid), .wb_tag(wb_tag), .wb_data(wb_data),
        .ret_valid(ret_valid), .ret_ok(ret_ok)
    );

    typedef struct packed {
        logic        rv;  logic [2:0] d;  logic [2:0] a;  logic [2:0] b;
        logic        wv;  logic [2:0] wt; logic [15:0] wd;
        logic        tv;
        logic        er;  logic [2:0] et;
        logic        ear; logic [15:0] ea;
        logic        ebr; logic [15:0] eb;
        logic        eok;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VEC [NV] = '{
        '{1'b1,3'd1,3'd2,3'd3, 1'b0,3'd0,16'h0,    1'b0, 1'b1,3'd0, 1'b1,16'h0,    1'b1,16'h0,    1'b0},
        '{1'b1,3'd2,3'd1,3'd2, 1'b0,3'd0,16'h0,    1'b0, 1'b1,3'd1, 1'b0,16'h0,    1'b1,16'h0,    1'b0},
        '{1'b1,3'd1,3'd1,3'd2, 1'b0,3'd0,16'h0,    1'b0, 1'b1,3'd2, 1'b0,16'h0,    1'b0,16'h1,    1'b0},
        '{1'b0,3'd0,3'd1,3'd2, 1'b1,3'd0,16'h1111, 1'b0, 1'b0,3'd0, 1'b0,16'h2,    1'b0,16'h1,    1'b0},
        '{1'b0,3'd0,3'd1,3'd2, 1'b0,3'd0,16'h0,    1'b1, 1'b0,3'd0, 1'b0,16'h2,    1'b0,16'h1,    1'b1},
        '{1'b0,3'd0,3'd1,3'd2, 1'b1,3'd2,16'h2222, 1'b1, 1'b0,3'd0, 1'b0,16'h2,    1'b0,16'h1,    1'b0},
        '{1'b0,3'd0,3'd1,3'd5, 1'b0,3'd0,16'h0,    1'b0, 1'b0,3'd0, 1'b1,16'h2222, 1'b1,16'h0,    1'b0},
        '{1'b0,3'd0,3'd2,3'd1, 1'b1,3'd1,16'h3333, 1'b1, 1'b0,3'd0, 1'b0,16'h1,    1'b1,16'h2222, 1'b0},
        '{1'b0,3'd0,3'd2,3'd1, 1'b0,3'd0,16'h0,    1'b1, 1'b0,3'd0, 1'b1,16'h3333, 1'b1,16'h2222, 1'b1},
        '{1'b0,3'd0,3'd2,3'd1, 1'b0,3'd0,16'h0,    1'b1, 1'b0,3'd0, 1'b1,16'h3333, 1'b1,16'h2222, 1'b1},
        '{1'b0,3'd0,3'd1,3'd2, 1'b0,3'd0,16'h0,    1'b1, 1'b0,3'd0, 1'b1,16'h2222, 1'b1,16'h3333, 1'b0}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // compares a source answer: value when ready, producer index when pending
    task automatic check_src(input logic rdy, input logic [15:0] v, input logic [2:0] t,
                             input logic erdy, input logic [15:0] e, input string req);
        check(rdy == erdy, {req, " ready"}, int'(rdy), int'(erdy));
        if (erdy) check(v == e, {req, " value"}, int'(v), int'(e));
        else      check(t == e[2:0], {req, " tag"}, int'(t), int'(e[2:0]));
    endtask

    task automatic idle();
        ren_valid = 1'b0; wb_valid = 1'b0; ret_valid = 1'b0;
    endtask

    initial begin
        #(20 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #2;
        // R8 reset state: empty buffer, architectural file zero
        check(ren_ready == 1'b1, "R2 ready after reset", int'(ren_ready), 1);
        check_src(src_a_rdy, src_a_val, src_a_tag, 1'b1, 16'h0, "R8 reset lookup");
        ret_valid = 1'b1; #1;
        check(ret_ok == 1'b0, "R6 retire when empty", int'(ret_ok), 0);
        idle();

        // R1 R3 R4 R5 R6 R7 R8 vector walk
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            ren_valid = VEC[i].rv; ren_dst = VEC[i].d;
            ren_src_a = VEC[i].a;  ren_src_b = VEC[i].b;
            wb_valid = VEC[i].wv;  wb_tag = VEC[i].wt; wb_data = VEC[i].wd;
            ret_valid = VEC[i].tv;
            #2;
            if (VEC[i].rv) begin
                check(ren_ready == VEC[i].er, "R1 ready", int'(ren_ready), int'(VEC[i].er));
                check(ren_tag == VEC[i].et, "R1 tag", int'(ren_tag), int'(VEC[i].et));
            end
            check_src(src_a_rdy, src_a_val, src_a_tag, VEC[i].ear, VEC[i].ea, "R3/R4/R5/R7 src a");
            check_src(src_b_rdy, src_b_val, src_b_tag, VEC[i].ebr, VEC[i].eb, "R4/R5/R8 src b");
            check(ret_ok == VEC[i].eok, "R6 ret_ok", int'(ret_ok), int'(VEC[i].eok));
        end
        @(negedge clk);
        idle();

        // R1 wrap and R2 full stall: head is 3 here
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            ren_valid = 1'b1; ren_dst = 3'd4; ren_src_a = 3'd4; ren_src_b = 3'd0;
            #2;
            check(ren_ready == 1'b1, "R2 ready while filling", int'(ren_ready), 1);
            check(ren_tag == 3'((3 + k) % 8), "R1 wrap tag", int'(ren_tag), (3 + k) % 8);
        end
        @(negedge clk);
        ren_valid = 1'b1; ren_dst = 3'd6; ren_src_a = 3'd4; ren_src_b = 3'd6;
        #2;
        check(ren_ready == 1'b0, "R2 full stalls", int'(ren_ready), 0);
        check_src(src_a_rdy, src_a_val, src_a_tag, 1'b0, 16'h2, "R3 newest of eight");
        @(negedge clk);
        ren_valid = 1'b0; ren_src_b = 3'd6;
        #2;
        check_src(src_b_rdy, src_b_val, src_b_tag, 1'b1, 16'h0, "R2 refused request left no entry");
        wb_valid = 1'b1; wb_tag = 3'd3; wb_data = 16'h4444;
        @(negedge clk);
        wb_valid = 1'b0; ret_valid = 1'b1;
        #2;
        check(ret_ok == 1'b1, "R6 retire from full", int'(ret_ok), 1);
        @(negedge clk);
        ret_valid = 1'b0; ren_valid = 1'b1; ren_dst = 3'd7;
        #2;
        check(ren_ready == 1'b1, "R2 ready after drain", int'(ren_ready), 1);
        check(ren_tag == 3'd3, "R2 head held during stall", int'(ren_tag), 3);
        @(negedge clk);
        idle();

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule